// File: doc/BRIEF.md
# Gated-Input Decimating Filter Leg

This block filters and decimates one real-valued leg of a complex baseband stream. Two copies make up a complex path, one for the in-phase leg and one for the quadrature leg. A select input, held steady while the block is out of reset, picks one of three behaviours that share one datapath. The first is a third-order cascaded integrator-comb decimator. The second is an integrate-and-dump filter. The third is a straight pass-through with no decimation.

Samples enter in one of two ways. In gated mode a sample is taken only on clocks where the input-valid strobe is high. In interpolated mode the sample rate equals the clock rate, so every clock delivers a sample. The integrators pass a valid flag down with the data one clock per stage. The three integrators therefore cost three clocks of latency, not three sample periods. The comb and dump registers are enabled only at the output rate. The counter that sets the decimation ratio counts samples, not clocks. All internal words are carried at full growth, so wraparound in the integrators cancels out in the combs.

Top module: `dec_filter_leg`

## Requirements
- R1: While reset is held and on the first clock after it, `sample_vld_o` is 0 and `sample_o` is 0.
- R2: With `filt_sel_i` at 2'b00 or 2'b11 (pass-through), each accepted sample appears sign-extended to OW bits. `sample_vld_o` is high in the clock after the edge that took the sample.
- R3: With `gate_sel_i` at 1 (gated), a sample is accepted only on an edge where `sample_vld_i` is 1. On other edges the value on `sample_i` has no effect on any output, and in pass-through mode `sample_vld_o` stays low after such an edge.
- R4: With `gate_sel_i` at 0 (interpolated), every edge accepts `sample_i` and `sample_vld_i` is ignored.
- R5: With `filt_sel_i` at 2'b01 (integrate-and-dump), each output is the OW-bit modular sum of R consecutive accepted samples. It is valid in the clock after the edge that took the Rth sample. The accumulator then restarts from zero.
- R6: With `filt_sel_i` at 2'b10 (CIC), each output equals three cascaded running sums of the accepted samples, differenced three times at the decimated rate, all modulo 2^OW. For a constant input c, every output from the third onward equals c·R³.
- R7: In CIC mode the integrators take exactly 3 clocks. `sample_vld_o` rises in the clock after the fifth edge that follows the edge taking the Rth sample of a group, whatever gaps lie between samples.
- R8: The effective ratio R is `ratio_i`, or 1 when `ratio_i` is 0. The sample counter stays below R. There is one output per R accepted samples, and each output's valid is a single clock wide. OW = DW + 3·RW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | DW | Signed input sample |
| sample_vld_i | input | 1 | Input-valid strobe (used in gated mode) |
| gate_sel_i | input | 1 | 1 = gated input, 0 = interpolated input |
| filt_sel_i | input | 2 | 00/11 pass-through, 01 integrate-and-dump, 10 CIC |
| ratio_i | input | RW | Decimation ratio (0 treated as 1) |
| sample_o | output | OW | Filtered signed output sample |
| sample_vld_o | output | 1 | Output-valid strobe |

## Verification
The hardest case to reach is a CIC output whose timing proves the integrators counted in clocks and not in samples. That needs the Rth sample of a group to arrive after irregular gaps. It also needs the full-scale extremes of the input to drive the integrators through wraparound. The stimulus sweeps every filter select and both input modes over a range of ratios. It uses pseudo-random valid gaps and injects runs of the most negative and most positive codes. Each output is compared against an arithmetic model on both its value and the exact clock it appears. In interpolated runs the bench toggles `sample_vld_i` and keeps changing `sample_i` throughout, so the model must accept every clock for the results to match.

// File: rtl/dfl_pkg.sv
package dfl_pkg;

  typedef enum logic [1:0] {
    FT_PASS  = 2'b00,
    FT_DUMP  = 2'b01,
    FT_CIC3  = 2'b10,
    FT_SPARE = 2'b11
  } filt_e;

  localparam int CIC_STAGES = 3;

endpackage

// File: rtl/dfl_dec_counter.sv
module dfl_dec_counter #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [RW-1:0] ratio,
  output logic          last,
  output logic [RW-1:0] cnt_o
);

  function automatic logic [RW-1:0] eff_ratio(input logic [RW-1:0] r);
    return (r == '0) ? RW'(1) : r;
  endfunction

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] top_val;

  assign top_val = eff_ratio(ratio) - RW'(1);
  assign last    = tick && (cnt_q >= top_val);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= last ? '0 : cnt_q + RW'(1);
    end
  end

endmodule

// File: rtl/dfl_integ_chain.sv
module dfl_integ_chain #(
  parameter int W = 20,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic [N-1:0] stage_vld
);

  logic [W-1:0] acc_w [N];
  logic [N-1:0] vld_w;

  for (genvar k = 0; k < N; k++) begin : g_int
    logic [W-1:0] acc_q;
    logic         vld_q;
    logic [W-1:0] src;
    logic         sen;

    if (k == 0) begin : g_head
      assign src = x;
      assign sen = en;
    end else begin : g_tail
      assign src = acc_w[k-1];
      assign sen = vld_w[k-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= sen;
        if (sen) acc_q <= acc_q + src;
      end
    end

    assign acc_w[k] = acc_q;
    assign vld_w[k] = vld_q;
  end

  assign y         = acc_w[N-1];
  assign stage_vld = vld_w;

endmodule

// File: rtl/dfl_comb_chain.sv
module dfl_comb_chain #(
  parameter int W = 20,
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         y_vld
);

  logic [W-1:0] diff_w [N];
  logic [N-1:0] vld_w;

  for (genvar k = 0; k < N; k++) begin : g_cmb
    logic [W-1:0] diff_q;
    logic [W-1:0] hist_q;
    logic         vld_q;
    logic [W-1:0] src;
    logic         sen;

    if (k == 0) begin : g_head
      assign src = x;
      assign sen = go;
    end else begin : g_tail
      assign src = diff_w[k-1];
      assign sen = vld_w[k-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        diff_q <= '0;
        hist_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        vld_q <= sen;
        if (sen) begin
          diff_q <= src - hist_q;
          hist_q <= src;
        end
      end
    end

    assign diff_w[k] = diff_q;
    assign vld_w[k]  = vld_q;
  end

  assign y     = diff_w[N-1];
  assign y_vld = vld_w[N-1];

endmodule

// File: rtl/dfl_dump_acc.sv
module dfl_dump_acc #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         dump,
  input  logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         y_vld,
  output logic [W-1:0] acc_o
);

  logic [W-1:0] acc_q;
  logic [W-1:0] out_q;
  logic         vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= en && dump;
      if (en) begin
        if (dump) begin
          out_q <= acc_q + x;
          acc_q <= '0;
        end else begin
          acc_q <= acc_q + x;
        end
      end
    end
  end

  assign y     = out_q;
  assign y_vld = vld_q;
  assign acc_o = acc_q;

endmodule

// File: rtl/dec_filter_leg.sv
module dec_filter_leg #(
  parameter int DW = 8,
  parameter int RW = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic signed [DW-1:0]         sample_i,
  input  logic                         sample_vld_i,
  input  logic                         gate_sel_i,
  input  logic [1:0]                   filt_sel_i,
  input  logic [RW-1:0]                ratio_i,
  output logic signed [DW+3*RW-1:0]    sample_o,
  output logic                         sample_vld_o
);
  import dfl_pkg::*;

  localparam int OW = DW + CIC_STAGES * RW;

  function automatic logic [OW-1:0] widen(input logic [DW-1:0] s);
    return {{(OW-DW){s[DW-1]}}, s};
  endfunction

  filt_e         mode;
  logic          is_cic;
  logic          is_dump;
  logic          is_pass;
  logic          en_in;
  logic [OW-1:0] x_wide;

  assign mode    = filt_e'(filt_sel_i);
  assign is_cic  = (mode == FT_CIC3);
  assign is_dump = (mode == FT_DUMP);
  assign is_pass = (mode == FT_PASS) || (mode == FT_SPARE);
  assign en_in   = gate_sel_i ? sample_vld_i : 1'b1;
  assign x_wide  = widen(sample_i);

  // integrator chain (CIC)
  logic                  cic_en;
  logic [OW-1:0]         integ_y;
  logic [CIC_STAGES-1:0] integ_v;

  assign cic_en = en_in && is_cic;

  dfl_integ_chain #(.W(OW), .N(CIC_STAGES)) u_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cic_en),
    .x         (x_wide),
    .y         (integ_y),
    .stage_vld (integ_v)
  );

  // shared decimation counter
  logic          dump_en;
  logic          cnt_tick;
  logic          cnt_last;
  logic [RW-1:0] cnt_q;
  logic          comb_go;
  logic          dump_fire;

  assign dump_en   = en_in && is_dump;
  assign cnt_tick  = (is_cic && integ_v[CIC_STAGES-1]) || dump_en;
  assign comb_go   = cnt_last && is_cic;
  assign dump_fire = cnt_last && is_dump;

  dfl_dec_counter #(.RW(RW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (cnt_tick),
    .ratio (ratio_i),
    .last  (cnt_last),
    .cnt_o (cnt_q)
  );

  // output-rate comb section
  logic [OW-1:0] comb_y;
  logic          comb_v;

  dfl_comb_chain #(.W(OW), .N(CIC_STAGES)) u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (comb_go),
    .x     (integ_y),
    .y     (comb_y),
    .y_vld (comb_v)
  );

  // integrate-and-dump
  logic [OW-1:0] dump_y;
  logic          dump_v;
  logic [OW-1:0] acc_q;

  dfl_dump_acc #(.W(OW)) u_dump (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (dump_en),
    .dump  (dump_fire),
    .x     (x_wide),
    .y     (dump_y),
    .y_vld (dump_v),
    .acc_o (acc_q)
  );

  // pass-through register
  logic [OW-1:0] pass_q;
  logic          pass_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_q <= '0;
      pass_v <= 1'b0;
    end else begin
      pass_v <= en_in && is_pass;
      if (en_in && is_pass) pass_q <= x_wide;
    end
  end

  always_comb begin
    unique case (mode)
      FT_CIC3: begin
        sample_o     = comb_y;
        sample_vld_o = comb_v;
      end
      FT_DUMP: begin
        sample_o     = dump_y;
        sample_vld_o = dump_v;
      end
      default: begin
        sample_o     = pass_q;
        sample_vld_o = pass_v;
      end
    endcase
  end

endmodule

// File: rtl/dfl_chk.sv
module dfl_chk #(
  parameter int DW = 8,
  parameter int RW = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [DW-1:0]         sample_i,
  input logic                  sample_vld_i,
  input logic                  gate_sel_i,
  input logic [1:0]            filt_sel_i,
  input logic [RW-1:0]         ratio_i,
  input logic [DW+3*RW-1:0]    sample_o,
  input logic                  sample_vld_o,
  input logic                  en_in,
  input logic [2:0]            integ_v,
  input logic                  dump_fire,
  input logic [DW+3*RW-1:0]    acc_q,
  input logic [RW-1:0]         cnt_q
);
  localparam int OW = DW + 3 * RW;

  logic          pass_sel;
  logic          cic_sel;
  logic [OW-1:0] in_ext;
  logic [RW-1:0] r_eff;

  assign pass_sel = (filt_sel_i == 2'b00) || (filt_sel_i == 2'b11);
  assign cic_sel  = (filt_sel_i == 2'b10);
  assign in_ext   = {{(OW-DW){sample_i[DW-1]}}, sample_i};
  assign r_eff    = (ratio_i == '0) ? RW'(1) : ratio_i;

  AST_PASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_sel && en_in) |=> (sample_vld_o && sample_o == $past(in_ext))); // R2

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_sel && gate_sel_i && !sample_vld_i) |=> !sample_vld_o); // R3

  AST_INTERP_EACH: assert property (@(posedge clk) disable iff (!rst_n)
    (cic_sel && !gate_sel_i) |=> integ_v[0]); // R4

  AST_DUMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dump_fire |=> (acc_q == '0)); // R5

  AST_INTEG_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cic_sel && en_in) |-> ##3 integ_v[2]); // R7

  AST_CIC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cic_sel && sample_vld_o) |-> $past(integ_v[2], 3)); // R7

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < r_eff); // R8

endmodule

bind dec_filter_leg dfl_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_i     (sample_i),
  .sample_vld_i (sample_vld_i),
  .gate_sel_i   (gate_sel_i),
  .filt_sel_i   (filt_sel_i),
  .ratio_i      (ratio_i),
  .sample_o     (sample_o),
  .sample_vld_o (sample_vld_o),
  .en_in        (en_in),
  .integ_v      (integ_v),
  .dump_fire    (dump_fire),
  .acc_q        (acc_q),
  .cnt_q        (cnt_q)
);

// File: tb/sim_dec_filter_leg.sv
module sim_dec_filter_leg;
  localparam int DW = 8;
  localparam int RW = 4;
  localparam int OW = DW + 3 * RW;
  localparam int NS = 96;
  localparam int TAIL = 12;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic                 din_vld = 1'b0;
  logic                 gsel = 1'b0;
  logic [1:0]           fsel = 2'b00;
  logic [RW-1:0]        ratio = '0;
  logic signed [OW-1:0] dout;
  logic                 dout_vld;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  int            exp_c[$];
  logic [OW-1:0] exp_v[$];
  int            got_c[$];
  logic [OW-1:0] got_v[$];

  dec_filter_leg #(.DW(DW), .RW(RW)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (din),
    .sample_vld_i (din_vld),
    .gate_sel_i   (gsel),
    .filt_sel_i   (fsel),
    .ratio_i      (ratio),
    .sample_o     (dout),
    .sample_vld_o (dout_vld)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // One configuration: reset, drive, model, compare value and arrival clock.
  task automatic run(input logic [1:0] ft, input logic gm, input logic [RW-1:0] r, input bit dc);
    int            eff;
    int            cnt;
    int            last;
    string         tag;
    logic [OW-1:0] s1, s2, s3, z1, z2, z3, c1, c2, acc, x, yv;
    logic signed [DW-1:0] d;
    logic          v;
    logic          take;
    eff = (r == 0) ? 1 : int'(r);
    cnt = 0;
    {s1, s2, s3, z1, z2, z3, c1, c2, acc} = '0;
    exp_c.delete(); exp_v.delete(); got_c.delete(); got_v.delete();
    tag = (ft == 2'b10) ? "R6" : (ft == 2'b01) ? "R5" : "R2";

    @(negedge clk);
    fsel = ft; gsel = gm; ratio = r; rst_n = 1'b0;
    din = 8'sh55; din_vld = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state observed at the ports
    chk(dout_vld == 1'b0 && dout == '0,
        $sformatf("R1 reset out=%0h vld=%0b exp 0/0", dout, dout_vld));
    rst_n = 1'b1;

    for (int j = 0; j < NS + TAIL; j++) begin
      if (j < NS) begin
        step_lfsr();
        if (dc) d = -8'sd100;
        else if (lfsr[9:8] == 2'b00) d = -8'sd128;
        else if (lfsr[9:8] == 2'b01) d = 8'sd127;
        else d = lfsr[7:0];
        v = gm ? (lfsr[12] | lfsr[13]) : lfsr[14];
      end else begin
        d = '0;
        v = 1'b0;
        if (!gm) begin step_lfsr(); v = lfsr[3]; end  // R4: toggling strobe ignored
      end
      din = d; din_vld = v;
      take = gm ? v : 1'b1;  // R3 / R4 acceptance rule
      if (take) begin
        x = OW'(int'(d));
        if (ft == 2'b01) begin
          if (cnt == eff - 1) begin
            exp_c.push_back(cyc + 1); exp_v.push_back(acc + x);
            acc = '0; cnt = 0;
          end else begin
            acc = acc + x; cnt++;
          end
        end else if (ft == 2'b10) begin
          s1 = s1 + x; s2 = s2 + s1; s3 = s3 + s2;
          if (cnt == eff - 1) begin
            cnt = 0;
            c1 = s3 - z1; z1 = s3;
            c2 = c1 - z2; z2 = c1;
            yv = c2 - z3; z3 = c2;
            exp_c.push_back(cyc + 6); exp_v.push_back(yv);  // R7: 3 integrator + 3 comb edges
          end else begin
            cnt++;
          end
        end else begin
          exp_c.push_back(cyc + 1); exp_v.push_back(x);
        end
      end
      @(negedge clk);
      if (dout_vld) begin got_c.push_back(cyc); got_v.push_back(dout); end
    end
    last = cyc;
    while (exp_c.size() > 0 && exp_c[exp_c.size()-1] > last) begin
      void'(exp_c.pop_back()); void'(exp_v.pop_back());
    end

    // R8: one output per R accepted samples, single-clock valids
    chk(got_c.size() == exp_c.size(),
        $sformatf("R8 ft=%0d g=%0d r=%0d outputs=%0d exp %0d", ft, gm, r, got_c.size(), exp_c.size()));
    for (int k = 0; k < got_c.size() && k < exp_c.size(); k++) begin
      chk(got_c[k] == exp_c[k] && got_v[k] == exp_v[k],
          $sformatf("%s ft=%0d g=%0d r=%0d idx=%0d got %0h@%0d exp %0h@%0d",
                    tag, ft, gm, r, k, got_v[k], got_c[k], exp_v[k], exp_c[k]));
    end

    if (dc) begin
      // R6: constant input c gives c*R^3 from the third output on
      for (int k = 2; k < got_v.size(); k++) begin
        yv = OW'(-100 * eff * eff * eff);
        chk(got_v[k] == yv,
            $sformatf("R6 dc r=%0d idx=%0d got %0h exp %0h", r, k, got_v[k], yv));
      end
    end
  endtask

  initial begin
    logic [RW-1:0] rlist [6];
    rlist[0] = 4'd0; rlist[1] = 4'd1; rlist[2] = 4'd2;
    rlist[3] = 4'd3; rlist[4] = 4'd7; rlist[5] = 4'd15;
    for (int f = 0; f < 4; f++) begin
      for (int g = 0; g < 2; g++) begin
        for (int i = 0; i < 6; i++) begin
          run(2'(f), 1'(g), rlist[i], 1'b0);
        end
      end
    end
    run(2'b10, 1'b1, 4'd4, 1'b1);
    run(2'b10, 1'b0, 4'd15, 1'b1);
    finish_up();
  end

endmodule